// File: doc/BRIEF.md
# Opcode-Steered Two's-Complement Adder/Subtractor

This block is a purely combinational datapath. It takes four 8-bit data words and a 5-bit opcode. Two fields of the opcode each pick one of the four words, one field for each operand. A further opcode bit chooses whether the two chosen words are added or whether the second is subtracted from the first. The arithmetic uses two's complement on an eight-stage ripple-carry chain. Each stage is a full adder made from two half adders.

The block outputs the low eight bits of the arithmetic result and a flag for signed overflow. The flag is raised when the carry entering the top bit differs from the carry leaving it. The carry out of the chain is not exported. The block has no clock and no storage: its outputs follow its inputs after propagation delay alone. A surrounding pipeline can register them wherever its timing needs.

The block can be used as a small operand-select-and-add stage. One example is an address or offset unit in which a control word names both sources and the operation.

Top module: `opsel_addsub`

## Requirements
- R1: When opcode bit 4 is 0, `result` equals (first operand + second operand) modulo 256.
- R2: When opcode bit 4 is 1, `result` equals (first operand − second operand) modulo 256. The second operand is bit-inverted and a carry of 1 enters bit 0.
- R3: Opcode bits 3:2 choose the first operand: 00 selects `data0`, 01 selects `data1`, 10 selects `data2` and 11 selects `data3`.
- R4: Opcode bits 1:0 choose the second operand with the same encoding as R3, independently of bits 3:2.
- R5: `overflow` is 1 exactly when the true signed result, with the operands read as signed 8-bit values, lies outside −128..127. For example, 0x7F + 0x01 gives `result` 0x80 with `overflow` 1.
- R6: The carry out of bit 7 is discarded and has no effect on `overflow` by itself. For example, 0xFF + 0x01 gives `result` 0x00 with `overflow` 0.
- R7: When both selector fields name the same input and bit 4 is 1, `result` is 0x00 and `overflow` is 0, whatever the data.
- R8: Subtracting 0x80 from 0x00 gives `result` 0x80 with `overflow` 1. Subtracting 0x80 from 0xFF gives 0x7F with `overflow` 0.
- R9: The block holds no state. `result` and `overflow` settle within the same cycle as any change on `data0`..`data3` or `opcode`, and depend only on the current input values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data0 | input | 8 | Data word, selector code 00 |
| data1 | input | 8 | Data word, selector code 01 |
| data2 | input | 8 | Data word, selector code 10 |
| data3 | input | 8 | Data word, selector code 11 |
| opcode | input | 5 | Bit 4 chooses add (0) or subtract (1); bits 3:2 choose the first operand; bits 1:0 choose the second operand |
| result | output | 8 | Low eight bits of the sum or difference |
| overflow | output | 1 | Signed overflow of the operation |

## Verification
The bench covers every pair of 8-bit operands, both added and subtracted. This exposes a chain that drops or misroutes a carry between stages: such a chain gives wrong sums exactly where long carry runs occur, such as 0xFF + 0x01. The same sweep exposes an overflow flag taken from the plain carry out. That flag would fire on 0xFF + 0x01 and stay silent on 0x7F + 0x01. It also exposes a subtractor that forgets the carry into bit 0, which would produce one's-complement differences that are short by one.

A sweep of all 32 opcodes runs against distinct data words. It catches swapped or mirrored selector fields and selectors that decode a code to the wrong input. It also catches an operation bit taken from the wrong position.

Directed cases cover self-subtraction and the most negative value. Self-subtraction must give zero, and a decoding that aliases the two fields would give a non-zero result there. The most negative value, 0x80, shows whether negation of the second operand is handled at the signed boundary.

// File: rtl/opsel_pkg.sv
package opsel_pkg;

    // Data path width and the number of selectable inputs.
    localparam int unsigned DATA_W   = 8;
    localparam int unsigned NUM_SRC  = 4;
    localparam int unsigned SEL_W    = $clog2(NUM_SRC);

    // Opcode layout: [OP_SUB_BIT] operation, [SRC_A_HI:SRC_A_LO] first
    // operand, [SRC_B_HI:SRC_B_LO] second operand.
    localparam int unsigned SRC_B_LO   = 0;
    localparam int unsigned SRC_B_HI   = SRC_B_LO + SEL_W - 1;
    localparam int unsigned SRC_A_LO   = SRC_B_HI + 1;
    localparam int unsigned SRC_A_HI   = SRC_A_LO + SEL_W - 1;
    localparam int unsigned OP_SUB_BIT = SRC_A_HI + 1;
    localparam int unsigned OPC_W      = OP_SUB_BIT + 1;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [SEL_W-1:0]  sel_t;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } arith_op_e;

    typedef struct packed {
        arith_op_e op;
        sel_t      src_a;
        sel_t      src_b;
    } opc_fields_t;

    function automatic opc_fields_t split_opcode(input logic [OPC_W-1:0] opc);
        opc_fields_t f;
        f.op    = arith_op_e'(opc[OP_SUB_BIT]);
        f.src_a = opc[SRC_A_HI:SRC_A_LO];
        f.src_b = opc[SRC_B_HI:SRC_B_LO];
        return f;
    endfunction

endpackage

// File: rtl/opsel_half_add.sv
module opsel_half_add (
    input  logic x_in,
    input  logic y_in,
    output logic sum_out,
    output logic carry_out
);

    assign sum_out   = x_in ^ y_in;
    assign carry_out = x_in & y_in;

endmodule

// File: rtl/opsel_full_add.sv
module opsel_full_add (
    input  logic x_in,
    input  logic y_in,
    input  logic c_in,
    output logic sum_out,
    output logic c_out
);

    logic part_sum;
    logic part_carry;
    logic late_carry;

    // First half adder combines the two operand bits.
    opsel_half_add u_ha_lo (
        .x_in      (x_in),
        .y_in      (y_in),
        .sum_out   (part_sum),
        .carry_out (part_carry)
    );

    // Second half adder folds in the incoming carry.
    opsel_half_add u_ha_hi (
        .x_in      (part_sum),
        .y_in      (c_in),
        .sum_out   (sum_out),
        .carry_out (late_carry)
    );

    // Both half-adder carries can never be 1 together, so OR merges them.
    assign c_out = part_carry | late_carry;

    always_comb begin
        p_fa_sum_r1: assert ({c_out, sum_out} == 2'(x_in) + 2'(y_in) + 2'(c_in))
            else $error("full adder stage arithmetic broken");
    end

endmodule

// File: rtl/opsel_src_pick.sv
module opsel_src_pick #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned COUNT = 4,
    localparam int unsigned SW   = $clog2(COUNT)
) (
    input  logic [COUNT-1:0][WIDTH-1:0] src_in,
    input  logic [SW-1:0]               pick,
    output logic [WIDTH-1:0]            word_out
);

    always_comb begin
        word_out = '0;
        for (int unsigned k = 0; k < COUNT; k++) begin
            if (pick == SW'(k)) begin
                word_out = src_in[k];
            end
        end
    end

    always_comb begin
        p_pick_matches_r3: assert (word_out == src_in[pick])
            else $error("selector forwarded the wrong source");
    end

endmodule

// File: rtl/opsel_ripple_addsub.sv
module opsel_ripple_addsub #(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             do_sub,
    output logic [WIDTH-1:0] diff_sum,
    output logic             sgn_ovf
);

    logic [WIDTH:0]   chain;
    logic [WIDTH-1:0] b_adj;

    // Subtraction: invert the second operand and inject a carry into bit 0.
    assign b_adj    = op_b ^ {WIDTH{do_sub}};
    assign chain[0] = do_sub;

    for (genvar g = 0; g < WIDTH; g++) begin : g_stage
        opsel_full_add u_fa (
            .x_in    (op_a[g]),
            .y_in    (b_adj[g]),
            .c_in    (chain[g]),
            .sum_out (diff_sum[g]),
            .c_out   (chain[g+1])
        );
    end

    // Signed overflow: carry into the top bit disagrees with carry out of it.
    assign sgn_ovf = chain[WIDTH] ^ chain[WIDTH-1];

    always_comb begin
        if (!do_sub) begin
            p_add_value_r1: assert (diff_sum == WIDTH'(op_a + op_b))
                else $error("sum differs from modular addition");
        end else begin
            p_sub_value_r2: assert (diff_sum == WIDTH'(op_a - op_b))
                else $error("difference differs from modular subtraction");
        end
    end

    // Sign-rule form of overflow, independent of the carry chain taps.
    logic eff_b_sign;
    assign eff_b_sign = op_b[WIDTH-1] ^ do_sub;

    always_comb begin
        p_ovf_sign_rule_r5: assert (sgn_ovf ==
                ((op_a[WIDTH-1] == eff_b_sign) && (diff_sum[WIDTH-1] != op_a[WIDTH-1])))
            else $error("overflow flag disagrees with sign rule");
    end

endmodule

// File: rtl/opsel_addsub.sv
module opsel_addsub
    import opsel_pkg::*;
(
    input  logic [DATA_W-1:0] data0,
    input  logic [DATA_W-1:0] data1,
    input  logic [DATA_W-1:0] data2,
    input  logic [DATA_W-1:0] data3,
    input  logic [OPC_W-1:0]  opcode,
    output logic [DATA_W-1:0] result,
    output logic              overflow
);

    opc_fields_t                   fld;
    logic [NUM_SRC-1:0][DATA_W-1:0] src_bank;
    word_t                         opnd_a;
    word_t                         opnd_b;

    assign fld      = split_opcode(opcode);
    assign src_bank = {data3, data2, data1, data0};

    opsel_src_pick #(
        .WIDTH (DATA_W),
        .COUNT (NUM_SRC)
    ) u_pick_a (
        .src_in   (src_bank),
        .pick     (fld.src_a),
        .word_out (opnd_a)
    );

    opsel_src_pick #(
        .WIDTH (DATA_W),
        .COUNT (NUM_SRC)
    ) u_pick_b (
        .src_in   (src_bank),
        .pick     (fld.src_b),
        .word_out (opnd_b)
    );

    opsel_ripple_addsub #(
        .WIDTH (DATA_W)
    ) u_arith (
        .op_a     (opnd_a),
        .op_b     (opnd_b),
        .do_sub   (fld.op == OP_SUB),
        .diff_sum (result),
        .sgn_ovf  (overflow)
    );

    always_comb begin
        if (fld.op == OP_SUB && fld.src_a == fld.src_b) begin
            p_self_zero_r7: assert (result == '0 && !overflow)
                else $error("self-subtraction not zero");
        end
    end

    always_comb begin
        p_src_b_pick_r4: assert (opnd_b == src_bank[opcode[SRC_B_HI:SRC_B_LO]])
            else $error("second operand drawn from wrong field");
    end

endmodule

// File: tb/opsel_addsub_tb_top.sv
module opsel_addsub_tb_top;

    logic [7:0] d0, d1, d2, d3;
    logic [4:0] opc;
    logic [7:0] res;
    logic       ovf;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    int compared   = 0;
    int mismatched = 0;
    int wd_cycles  = 0;
    bit done       = 1'b0;

    opsel_addsub dut_i (
        .data0    (d0),
        .data1    (d1),
        .data2    (d2),
        .data3    (d3),
        .opcode   (opc),
        .result   (res),
        .overflow (ovf)
    );

    function automatic logic [7:0] pick_word(input logic [1:0] s);
        case (s)
            2'd0: return d0;
            2'd1: return d1;
            2'd2: return d2;
            default: return d3;
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] exp_r, input logic exp_o);
        compared++;
        if (res !== exp_r || ovf !== exp_o) begin
            mismatched++;
            $display("FAIL %s opc=%b d=%h/%h/%h/%h got r=%h o=%b expected r=%h o=%b",
                     req, opc, d0, d1, d2, d3, res, ovf, exp_r, exp_o);
        end
    endtask

    // Arithmetic reference from R1, R2, R5: signed integer math.
    task automatic apply_and_check(input string req);
        logic [7:0] a, b;
        int sa, sb, full;
        logic [7:0] er;
        logic eo;
        #1;
        a  = pick_word(opc[3:2]);
        b  = pick_word(opc[1:0]);
        sa = int'($signed(a));
        sb = int'($signed(b));
        full = opc[4] ? (sa - sb) : (sa + sb);
        er = 8'(opc[4] ? (int'(a) - int'(b)) : (int'(a) + int'(b)));
        eo = (full > 127) || (full < -128);
        check(req, er, eo);
    endtask

    always @(posedge clk) begin
        wd_cycles++;
        if (wd_cycles > 150000 && !done) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        // Initial state: zero inputs give zero result and no overflow (R9).
        d0 = 8'h00; d1 = 8'h00; d2 = 8'h00; d3 = 8'h00; opc = 5'b0_00_00;
        #1; check("R9 idle zero", 8'h00, 1'b0);

        // Directed corners.
        d0 = 8'h7F; d1 = 8'h01; opc = 5'b0_00_01;
        #1; check("R5 7F+01", 8'h80, 1'b1);
        d0 = 8'hFF; d1 = 8'h01; opc = 5'b0_00_01;
        #1; check("R6 FF+01", 8'h00, 1'b0);
        d0 = 8'h00; d1 = 8'h80; opc = 5'b1_00_01;
        #1; check("R8 00-80", 8'h80, 1'b1);
        d0 = 8'hFF; d1 = 8'h80; opc = 5'b1_00_01;
        #1; check("R8 FF-80", 8'h7F, 1'b0);
        d0 = 8'h80; d1 = 8'h80; opc = 5'b0_00_01;
        #1; check("R5 80+80", 8'h00, 1'b1);
        d0 = 8'h05; d1 = 8'h07; opc = 5'b1_00_01;
        #1; check("R2 05-07", 8'hFE, 1'b0);

        // R7: every source subtracted from itself.
        d0 = 8'h80; d1 = 8'hA5; d2 = 8'h7F; d3 = 8'hFF;
        for (int s = 0; s < 4; s++) begin
            opc = {1'b1, 2'(s), 2'(s)};
            #1; check("R7 self-sub", 8'h00, 1'b0);
        end

        // R3/R4: full opcode sweep over distinct words, several patterns.
        for (int p = 0; p < 4; p++) begin
            d0 = 8'h11 + 8'(p * 37); d1 = 8'h6A ^ 8'(p * 11);
            d2 = 8'hC3 - 8'(p * 5);  d3 = 8'h3C + 8'(p * 90);
            for (int o = 0; o < 32; o++) begin
                opc = 5'(o);
                apply_and_check("R3/R4 opcode sweep R3 R4");
            end
        end

        // R1/R2/R5/R6: exhaustive operand pairs, add then subtract.
        d2 = 8'h00; d3 = 8'h00;
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                d0 = 8'(a); d1 = 8'(b);
                opc = 5'b0_00_01;
                apply_and_check("R1 R5 R6 exhaustive add");
                opc = 5'b1_00_01;
                apply_and_check("R2 R5 exhaustive sub");
            end
        end

        // R9: output tracks an input change with no clock involvement.
        d0 = 8'h10; d1 = 8'h20; opc = 5'b0_00_01;
        #1; check("R9 track a", 8'h30, 1'b0);
        d1 = 8'h21;
        #1; check("R9 track b", 8'h31, 1'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule